// File: doc/BRIEF.md
# Byte-Addressed GPIO Port Register Block

This block holds the data and direction state for a bank of general-purpose pins arranged as ports of equal width (by default 8 ports of 32 pins, 256 pins in all). Every pin owns a private byte location in the low part of the address map, at an offset equal to its pin index (`port*32 + bit`). Software can drive or sample one pin with a single byte access, with no read-modify-write. A word access to the same region touches four neighbouring pins at once, one per byte lane.

Each port also has a 32-bit direction word in a separate window that starts at offset 0x2000, at `0x2000 + 4*port`. A direction bit of 1 turns the pin into an output: its output latch drives `pin_out` and its enable shows on `pin_oe`. The pin levels coming in from the pads pass through a two-stage synchronizer before any read can see them.

The slave port is a simple single-cycle request interface. Writes take effect at the clock edge that accepts them. Read data is registered, so it appears on `bus_rdata` after the edge that accepts the read and stays there until the next read.

Top module: `gpio_byte_port`

## Requirements
- R1: After reset every output latch and every direction bit is 0, so `pin_out` and `pin_oe` are all zero and every pin reads its synchronized input.
- R2: A byte write to offset p (p below 256, p = port*32 + bit) sets the latch of pin p to 1 when `bus_wdata[7:0]` is nonzero and clears it when zero; no other latch changes.
- R3: A word write to the pin region ignores `bus_addr[1:0]` and updates pins base..base+3, where base is the address rounded down to a multiple of 4; pin base+k takes 1 when byte lane k (`bus_wdata[8k+7:8k]`) is nonzero.
- R4: A word write to 0x2000 + 4*n loads the direction word of port n; bit b of that word drives `pin_oe[n*32+b]` (1 = output). A word read at the same offset returns it.
- R5: A pin read returns the pin value in bit 0 of each byte it covers, with the other seven bits of that byte zero. A byte read places the value in `bus_rdata[0]` and zeros the rest. A word read places pin base+k in bit 8k. For an output pin the value is its latch.
- R6: For an input pin a read returns the pad level through two synchronizer flops. A level applied just after edge E is first seen by a read accepted at edge E+3.
- R7: Offsets 0x100 to 0x1FFF, offsets from 0x2020 upward, and any byte access into the direction window are unmapped. They read as zero, and writes to them change neither latches nor directions.
- R8: `bus_rdata` is loaded only at an edge that accepts a read (`bus_sel`=1, `bus_wr`=0) and otherwise holds its value.
- R9: A write to a pin's latch while the pin is an input changes `pin_out` but not what reads of that pin return. A direction write never changes any latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 14 | Byte offset into the block |
| bus_wdata | input | 32 | Write data (byte access uses bits 7:0) |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 256 | Pad input levels, asynchronous |
| pin_out | output | 256 | Output latch per pin |
| pin_oe | output | 256 | Output enable per pin, from direction bits |

## Verification
Two functions can act on the same pin in one cycle: the synchronizer can take in a new pad level on the same edge at which the bus writes that pin's latch while the pin is still an input. The bench provokes this by changing `pin_in` at the same falling edge at which it issues the latch write. It then reads the pin at the second and third edges after the change. It expects the read to follow the synchronized pad level with its fixed two-stage delay and to ignore the latch, while `pin_out` follows the written value at once. When the direction is later flipped to output, the same read must switch to the latch.

// File: rtl/gpio_bp_pkg.sv
package gpio_bp_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_PIN  = 2'd1,
    RGN_DIR  = 2'd2
  } region_e;

endpackage

// File: rtl/gpio_bp_sync.sv
module gpio_bp_sync #(
  parameter int WIDTH  = 256,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_in;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bp_decode.sv
module gpio_bp_decode
  import gpio_bp_pkg::*;
#(
  parameter int          NUM_PORTS = 8,
  parameter int          PORT_W    = 32,
  parameter int          ADDR_W    = 14,
  parameter logic [13:0] DIR_BASE  = 14'h2000,
  localparam int NUM_PINS   = NUM_PORTS * PORT_W,
  localparam int PIN_IDX_W  = $clog2(NUM_PINS),
  localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  bus_word,
  input  logic [ADDR_W-1:0]     bus_addr,
  output region_e               region,
  output logic [PIN_IDX_W-1:0]  pin_base,
  output logic [PORT_IDX_W-1:0] port_idx
);

  localparam logic [ADDR_W-1:0] PIN_END  = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] DIR_SPAN = ADDR_W'(4 * NUM_PORTS);

  logic [ADDR_W-1:0] dir_off;
  logic              pin_hit;
  logic              dir_hit;

  always_comb begin
    dir_off  = bus_addr - ADDR_W'(DIR_BASE);
    pin_hit  = (bus_addr < PIN_END);
    dir_hit  = bus_word && (bus_addr >= ADDR_W'(DIR_BASE)) && (dir_off < DIR_SPAN);
    pin_base = bus_word ? {bus_addr[PIN_IDX_W-1:2], 2'b00} : bus_addr[PIN_IDX_W-1:0];
    port_idx = dir_off[PORT_IDX_W+1:2];
    if (pin_hit)      region = RGN_PIN;
    else if (dir_hit) region = RGN_DIR;
    else              region = RGN_NONE;
  end

endmodule

// File: rtl/gpio_bp_regs.sv
module gpio_bp_regs #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 32,
  parameter int DATA_W    = 32,
  localparam int NUM_PINS   = NUM_PORTS * PORT_W,
  localparam int PIN_IDX_W  = $clog2(NUM_PINS),
  localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LANES      = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_pin,
  input  logic                  wr_dir,
  input  logic                  wr_word,
  input  logic [PIN_IDX_W-1:0]  pin_base,
  input  logic [PORT_IDX_W-1:0] port_idx,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM_PINS-1:0]   latch_q,
  output logic [NUM_PINS-1:0]   dir_q
);

  logic [NUM_PINS-1:0] latch_nxt;
  logic [NUM_PINS-1:0] dir_nxt;

  always_comb begin
    latch_nxt = latch_q;
    if (wr_word) begin
      for (int k = 0; k < LANES; k++) begin
        latch_nxt[pin_base + PIN_IDX_W'(k)] = |wdata[8*k +: 8];
      end
    end else begin
      latch_nxt[pin_base] = |wdata[7:0];
    end
  end

  always_comb begin
    dir_nxt = dir_q;
    dir_nxt[port_idx * PORT_W +: PORT_W] = wdata[PORT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (wr_pin) latch_q <= latch_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= dir_nxt;
  end

endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
  import gpio_bp_pkg::*;
#(
  parameter int          NUM_PORTS   = 8,
  parameter int          PORT_W      = 32,
  parameter int          ADDR_W      = 14,
  parameter int          SYNC_STAGES = 2,
  parameter logic [13:0] DIR_BASE    = 14'h2000,
  localparam int NUM_PINS   = NUM_PORTS * PORT_W,
  localparam int DATA_W     = 32,
  localparam int LANES      = DATA_W / 8,
  localparam int PIN_IDX_W  = $clog2(NUM_PINS),
  localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_word,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  region_e               region;
  logic [PIN_IDX_W-1:0]  pin_base;
  logic [PORT_IDX_W-1:0] port_idx;
  logic [NUM_PINS-1:0]   sync_in;
  logic [NUM_PINS-1:0]   pin_val;
  logic                  wr_pin;
  logic                  wr_dir;
  logic                  rd_en;
  logic [DATA_W-1:0]     rdata_nxt;

  gpio_bp_decode #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .ADDR_W    (ADDR_W),
    .DIR_BASE  (DIR_BASE)
  ) decode_i (
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .region   (region),
    .pin_base (pin_base),
    .port_idx (port_idx)
  );

  gpio_bp_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_in)
  );

  assign wr_pin = bus_sel && bus_wr && (region == RGN_PIN);
  assign wr_dir = bus_sel && bus_wr && (region == RGN_DIR);
  assign rd_en  = bus_sel && !bus_wr;

  gpio_bp_regs #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .DATA_W    (DATA_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pin   (wr_pin),
    .wr_dir   (wr_dir),
    .wr_word  (bus_word),
    .pin_base (pin_base),
    .port_idx (port_idx),
    .wdata    (bus_wdata),
    .latch_q  (pin_out),
    .dir_q    (pin_oe)
  );

  // Output pins read back their latch, input pins their synchronized level.
  assign pin_val = (pin_oe & pin_out) | (~pin_oe & sync_in);

  always_comb begin
    rdata_nxt = '0;
    unique case (region)
      RGN_PIN: begin
        if (bus_word) begin
          for (int k = 0; k < LANES; k++) begin
            rdata_nxt[8*k] = pin_val[pin_base + PIN_IDX_W'(k)];
          end
        end else begin
          rdata_nxt[0] = pin_val[pin_base];
        end
      end
      RGN_DIR:  rdata_nxt[PORT_W-1:0] = pin_oe[port_idx * PORT_W +: PORT_W];
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rdata_nxt;
  end

endmodule

// File: rtl/gpio_byte_port_chk.sv
module gpio_byte_port_chk #(
  parameter int NUM_PINS = 256,
  parameter int ADDR_W   = 14,
  parameter int DIR_LO   = 'h2000,
  parameter int DIR_HI   = 'h2020
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic                bus_word,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  localparam int IDX_W = $clog2(NUM_PINS);

  logic in_pins;
  logic in_dir;
  logic [IDX_W-1:0] idx;
  logic [NUM_PINS-1:0] keep_mask;

  assign in_pins   = int'(bus_addr) < NUM_PINS;
  assign in_dir    = bus_word && int'(bus_addr) >= DIR_LO && int'(bus_addr) < DIR_HI;
  assign idx       = bus_addr[IDX_W-1:0];
  assign keep_mask = ~(NUM_PINS'(1) << idx);

  // R2: a byte write sets exactly the addressed latch
  a_r2_byte_write_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_word && in_pins) |=>
      (pin_out[$past(idx)] == ($past(bus_wdata[7:0]) != 8'd0)) &&
      (((pin_out ^ $past(pin_out)) & $past(keep_mask)) == '0));

  // R7: unmapped writes leave every latch and direction alone
  a_r7_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !in_pins && !in_dir) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R7: unmapped reads return zero
  a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !in_pins && !in_dir) |=> (bus_rdata == 32'd0));

  // R9: direction writes never touch the latches
  a_r9_dir_write_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && in_dir) |=> $stable(pin_out));

  // R5: pin reads carry only bit 0 of each byte
  a_r5_pin_read_bit0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && in_pins) |=> ((bus_rdata & 32'hFEFE_FEFE) == 32'd0));

  // R8: read data holds when no read is accepted
  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind gpio_byte_port gpio_byte_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DIR_LO   (int'(DIR_BASE)),
  .DIR_HI   (int'(DIR_BASE) + 4 * NUM_PORTS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_word  (bus_word),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_byte_port_tb.sv
`timescale 1ns/1ps
module gpio_byte_port_tb_top;

  localparam int NP = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr, bus_word;
  logic [13:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  logic [NP-1:0] m_latch, m_dir;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_byte_port dut_i (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_word (bus_word), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe)
  );

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic pval(input int p);
    return m_dir[p] ? m_latch[p] : pin_in[p];
  endfunction

  function automatic logic [31:0] exp_rd(input bit word, input int a);
    logic [31:0] r = '0;
    if (a < NP) begin
      if (word) for (int k = 0; k < 4; k++) r[8*k] = pval((a & ~3) + k);
      else r[0] = pval(a);
    end else if (word && a >= 'h2000 && a < 'h2020) begin
      r = m_dir[((a - 'h2000) >> 2) * 32 +: 32];
    end
    return r;
  endfunction

  task automatic model_wr(input bit word, input int a, input logic [31:0] d);
    if (a < NP) begin
      if (word) for (int k = 0; k < 4; k++) m_latch[(a & ~3) + k] = |d[8*k +: 8];
      else m_latch[a] = |d[7:0];
    end else if (word && a >= 'h2000 && a < 'h2020) begin
      m_dir[((a - 'h2000) >> 2) * 32 +: 32] = d;
    end
  endtask

  task automatic bus_write(input bit word, input int a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_word = word; bus_addr = 14'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_wr(word, a, d);
  endtask

  task automatic bus_read(input bit word, input int a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_word = word; bus_addr = 14'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic rd_check(input string req, input bit word, input int a);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_rd(word, a);
    bus_read(word, a, d);
    chk(req, NP'(d), NP'(e));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0017));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; m_latch = '0; m_dir = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    rd_check("R1 dir read", 1, 'h201C);

    // R2: single pin set/clear, nonzero byte counts as 1
    bus_write(0, 37, 32'h0000_0080);
    chk("R2 set pin 37", pin_out, m_latch);
    bus_write(0, 37, 32'hFFFF_FF00);
    chk("R2 clear pin 37", pin_out, m_latch);

    // R3: word write with misaligned address, per-lane values
    bus_write(1, 'h43, 32'h01_00_FF_02);
    chk("R3 word write lanes", pin_out, m_latch);

    // R4: direction of port 2 and readback
    bus_write(1, 'h2008, 32'h0000_000F);
    chk("R4 oe port 2", pin_oe, m_dir);
    rd_check("R4 dir readback", 1, 'h2008);

    // R5: output pins read their latch
    rd_check("R5 word read out pins", 1, 'h40);
    rd_check("R5 byte read out pin", 0, 'h42);

    // R7: unmapped write and byte access to direction window
    bus_write(1, 'h0100, 32'hFFFF_FFFF);
    bus_write(0, 'h2000, 32'h0000_00FF);
    bus_write(1, 'h2020, 32'hFFFF_FFFF);
    chk("R7 latch untouched", pin_out, m_latch);
    chk("R7 dir untouched", pin_oe, m_dir);
    rd_check("R7 byte dir read", 0, 'h2008);

    // R6 and R9: pad change coinciding with latch write on an input pin
    pin_in[5] = 1'b1;
    bus_write(0, 5, 32'h0);         // accepted at first edge after change
    chk("R9 latch follows write", pin_out, m_latch);
    bus_read(0, 5, d);              // accepted at second edge
    chk("R6 not yet visible", NP'(d), NP'(0));
    bus_read(0, 5, d);              // accepted at third edge
    chk("R6 visible at third edge", NP'(d), NP'(1));
    bus_write(1, 'h2000, 32'h0000_0020);
    chk("R9 dir write keeps latch", pin_out, m_latch);
    rd_check("R9 output reads latch", 0, 5);

    // R8: rdata holds across idle and write cycles
    bus_read(1, 'h2000, d);
    bus_write(0, 9, 32'h1);
    @(negedge clk);
    chk("R8 rdata held", NP'(bus_rdata), NP'(d));

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 9);
      int a;
      bit w = $urandom_range(0, 1) == 1;
      logic [31:0] dat = $urandom();
      if ($urandom_range(0, 3) == 0) dat = dat & 32'h0100_0100;
      case (sel)
        0, 1, 2: begin
          a = $urandom_range(0, NP - 1);
          bus_write(w, a, dat);
          chk(w ? "R3 rnd word write" : "R2 rnd byte write", pin_out, m_latch);
        end
        3: begin
          a = 'h2000 + 4 * $urandom_range(0, 7);
          bus_write(1, a, dat);
          chk("R4 rnd dir write", pin_oe, m_dir);
          chk("R9 rnd latch kept", pin_out, m_latch);
        end
        4, 5: begin
          a = $urandom_range(0, NP - 1);
          rd_check("R5 rnd pin read", w, a);
        end
        6: rd_check("R4 rnd dir read", 1, 'h2000 + 4 * $urandom_range(0, 7));
        7: begin
          a = ($urandom_range(0, 1) == 1) ? $urandom_range('h100, 'h1FFF)
                                          : $urandom_range('h2020, 'h3FFF);
          bus_write(w, a, dat);
          chk("R7 rnd unmapped write", pin_out | pin_oe, m_latch | m_dir);
          rd_check("R7 rnd unmapped read", w, a);
        end
        default: begin
          pin_in = {$urandom(), $urandom(), $urandom(), $urandom(),
                    $urandom(), $urandom(), $urandom(), $urandom()};
          repeat (3) @(negedge clk);
          rd_check("R6 rnd input read", 1, 4 * $urandom_range(0, 63));
        end
      endcase
    end

    done = 1;
    finish_run();
  end

endmodule